// File: doc/BRIEF.md
# Receive Interrupt Delay Timers

This block moderates receive interrupts. Each time a receive descriptor completes, the datapath sends a one-cycle completion pulse together with the frame length. The block then decides whether the receive-timer cause is raised at once or after a delay. Two countdown timers handle the delayed case. The packet timer restarts on every frame. The absolute timer starts once per burst and bounds the total wait. A separate comparison raises a small-frame cause for short frames.

Delays are counted in units of a shared delay-tick enable, so one tick period scales every delay. The interrupt controller receives one-cycle cause requests and the two pending flags. It can send a cancel strobe that stops both timers, for example when it posts an interrupt for another reason.

Top module: `rxdly_intr_timers`

## Requirements
- R1: After reset, `rxt_req`, `small_req`, `pkt_pend` and `abs_pend` are all 0.
- R2: A completion with `pkt_delay` nonzero loads the packet timer with the full `pkt_delay`. Any count already running is discarded. `pkt_pend` is 1 from the following cycle.
- R3: A running timer counts down by one only in cycles where `tick_en` is 1. On the tick that ends its D-th count, `rxt_req` is 1 for the next cycle and that timer's pending flag returns to 0 in that same cycle.
- R4: A completion starts the absolute timer with `abs_delay` only when `abs_delay` and `pkt_delay` are both nonzero and the absolute timer is not running. Later completions leave a running absolute count untouched.
- R5: A completion with `pkt_delay` equal to 0 makes `rxt_req` 1 in the next cycle and starts neither timer.
- R6: A completion with `done_len` less than or equal to a nonzero `small_thresh` makes `small_req` 1 for exactly the next cycle. A longer frame leaves `small_req` at 0.
- R7: When `small_thresh` is 0, `small_req` stays 0 for every frame length, including a length of 0.
- R8: A `cancel` cycle clears both pending flags, and neither timer raises a request that cycle. A completion in the same cycle is applied after the cancel and may start the timers again.
- R9: If a completion arrives on the tick that would end the packet timer, the restart wins and the packet timer raises no request.
- R10: When several receive-timer sources fire in the same cycle, they merge into a single one-cycle `rxt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Delay-tick enable; one tick is one unit of delay |
| done_vld | input | 1 | One-cycle descriptor-completion pulse |
| done_len | input | LEN_W | Frame length for the completion |
| pkt_delay | input | DLY_W | Packet delay in ticks; 0 selects the immediate cause |
| abs_delay | input | DLY_W | Absolute delay in ticks; 0 disables the absolute timer |
| small_thresh | input | LEN_W | Small-frame threshold; 0 disables detection |
| cancel | input | 1 | Stop both timers and clear their pending flags |
| rxt_req | output | 1 | One-cycle receive-timer cause request |
| small_req | output | 1 | One-cycle small-frame cause request |
| pkt_pend | output | 1 | Packet timer running |
| abs_pend | output | 1 | Absolute timer running |

## Verification
The assertions check on every cycle that:
- a load always leaves its timer pending;
- a stop or an expiry always clears it;
- a count never moves without a tick;
- the immediate cause follows a completion with a zero packet delay;
- a zero threshold never yields a small-frame request;
- the absolute timer only rises on a qualifying completion.

Only the bench scenarios can show the exact expiry cycle after D ticks spread over idle cycles. They also cover the restart-beats-expiry collision, cancel combined with a completion, once-per-burst absolute behaviour, and the merging of simultaneous expiries. The bench's reference model checks these outputs every clock.

// File: rtl/rxdly_pkg.sv
// Package: shared types for the receive interrupt delay timers.
// Assumes two timers, indexed by the constants below.
package rxdly_pkg;
    localparam int NUM_TMR = 2;
    localparam int PKT_IDX = 0;
    localparam int ABS_IDX = 1;

    // Per-cycle operation applied to one countdown timer.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STOP = 2'd2,
        OP_TICK = 2'd3
    } tmr_op_e;

    // Pick one operation with priority load > stop > tick > hold.
    function automatic tmr_op_e pick_op(input logic load, input logic stop,
                                        input logic tick);
        if (load)      return OP_LOAD;
        else if (stop) return OP_STOP;
        else if (tick) return OP_TICK;
        else           return OP_HOLD;
    endfunction
endpackage

// File: rtl/rxdly_countdown.sv
// Module: one-shot countdown timer.
// It counts load_val ticks and then flags expiry for one cycle.
// Assumes load_val is nonzero whenever op is OP_LOAD.
// expire is combinational and is valid only on an OP_TICK cycle.
module rxdly_countdown
    import rxdly_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_op_e          op,
    input  logic [CNT_W-1:0] load_val,
    output logic             pend,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    // Expiry: the last remaining count is consumed by this tick.
    assign expire = (op == OP_TICK) && pend_q && (cnt_q == CNT_ONE);
    assign pend   = pend_q;

    // Count state: load, stop, decrement on tick, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    cnt_q  <= load_val;
                    pend_q <= 1'b1;
                end
                OP_STOP: begin
                    cnt_q  <= '0;
                    pend_q <= 1'b0;
                end
                OP_TICK: begin
                    if (pend_q) begin
                        cnt_q  <= cnt_q - CNT_ONE;
                        pend_q <= (cnt_q != CNT_ONE);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_LOAD_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> pend); // R2
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STOP) |=> !pend); // R8
    AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !pend); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && op == OP_HOLD) |=> (pend && $stable(cnt_q))); // R3
endmodule

// File: rtl/rxdly_small_det.sv
// Module: small-frame comparator.
// hit is 1 when the threshold is nonzero and the length does not exceed it.
// Assumes the length and the threshold use the same unit.
module rxdly_small_det #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] thresh,
    output logic             hit
);
    // Compare: a zero threshold disables detection.
    always_comb begin
        hit = (thresh != '0) && (frame_len <= thresh);
    end
endmodule

// File: rtl/rxdly_intr_timers.sv
// Module: receive interrupt delay timers (top).
// It manages a packet timer and an absolute timer from completion pulses.
// It raises receive-timer and small-frame cause requests, each one cycle long.
// Assumes done_vld is a single-cycle pulse and the delay inputs are steady
// while a completion is presented.
module rxdly_intr_timers
    import rxdly_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             done_vld,
    input  logic [LEN_W-1:0] done_len,
    input  logic [DLY_W-1:0] pkt_delay,
    input  logic [DLY_W-1:0] abs_delay,
    input  logic [LEN_W-1:0] small_thresh,
    input  logic             cancel,
    output logic             rxt_req,
    output logic             small_req,
    output logic             pkt_pend,
    output logic             abs_pend
);
    logic [NUM_TMR-1:0] load_v;
    logic [NUM_TMR-1:0] pend_v;
    logic [NUM_TMR-1:0] exp_v;
    logic [DLY_W-1:0]   load_val [NUM_TMR];
    tmr_op_e            op_v     [NUM_TMR];
    logic               pkt_dly_on;
    logic               immed_rxt;
    logic               small_hit;
    logic               rxt_q;
    logic               small_q;

    // Start decisions: the packet timer restarts on every frame;
    // the absolute timer starts only when it is idle (or just cancelled).
    always_comb begin
        pkt_dly_on       = (pkt_delay != '0);
        immed_rxt        = done_vld && !pkt_dly_on;
        load_v[PKT_IDX]  = done_vld && pkt_dly_on;
        load_v[ABS_IDX]  = done_vld && pkt_dly_on && (abs_delay != '0)
                           && (!pend_v[ABS_IDX] || cancel);
        load_val[PKT_IDX] = pkt_delay;
        load_val[ABS_IDX] = abs_delay;
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        // Operation select per timer with fixed priority.
        always_comb begin
            op_v[i] = pick_op(load_v[i], cancel, tick_en);
        end

        rxdly_countdown #(
            .CNT_W(DLY_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op_v[i]),
            .load_val (load_val[i]),
            .pend     (pend_v[i]),
            .expire   (exp_v[i])
        );
    end

    rxdly_small_det #(
        .LEN_W(LEN_W)
    ) u_small (
        .frame_len (done_len),
        .thresh    (small_thresh),
        .hit       (small_hit)
    );

    // Cause registers: merge all receive-timer sources into one pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxt_q   <= 1'b0;
            small_q <= 1'b0;
        end else begin
            rxt_q   <= immed_rxt || (|exp_v);
            small_q <= done_vld && small_hit;
        end
    end

    assign rxt_req   = rxt_q;
    assign small_req = small_q;
    assign pkt_pend  = pend_v[PKT_IDX];
    assign abs_pend  = pend_v[ABS_IDX];

    AST_IMMEDIATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && pkt_delay == '0) |=> rxt_req); // R5
    AST_SMALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && small_thresh == '0) |=> !small_req); // R7
    AST_ABS_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abs_pend) |-> $past(done_vld && pkt_delay != '0 && abs_delay != '0)); // R4
    AST_CANCEL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !done_vld) |=> (!rxt_req && !pkt_pend && !abs_pend)); // R8
endmodule

// File: tb/tb_rxdly_intr_timers.sv
module tb_rxdly_intr_timers;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int DLY_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, done_vld = 1'b0, cancel = 1'b0;
    logic [LEN_W-1:0] done_len = '0, small_thresh = '0;
    logic [DLY_W-1:0] pkt_delay = '0, abs_delay = '0;
    logic rxt_req, small_req, pkt_pend, abs_pend;

    int checks = 0, failures = 0;
    bit finished = 0;
    int m_pc = 0, m_ac = 0;
    bit e_rxt = 0, e_small = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdly_intr_timers #(.LEN_W(LEN_W), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .done_vld(done_vld),
        .done_len(done_len), .pkt_delay(pkt_delay), .abs_delay(abs_delay),
        .small_thresh(small_thresh), .cancel(cancel), .rxt_req(rxt_req),
        .small_req(small_req), .pkt_pend(pkt_pend), .abs_pend(abs_pend));

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "rxt_req", int'(rxt_req), int'(e_rxt));
        chk(tag, "small_req", int'(small_req), int'(e_small));
        chk(tag, "pkt_pend", int'(pkt_pend), int'(m_pc != 0));
        chk(tag, "abs_pend", int'(abs_pend), int'(m_ac != 0));
    endtask

    // One clock: drive inputs, advance the reference model, compare after the edge.
    task automatic step(input bit d, input int len, input bit tk, input bit cn, input string tag);
        int pc, ac;
        bit pf, af, abs_run;
        done_vld = d; done_len = LEN_W'(len); tick_en = tk; cancel = cn;
        pc = m_pc; ac = m_ac; pf = 0; af = 0;
        if (cn) begin pc = 0; ac = 0; end
        abs_run = (ac != 0);
        if (!cn && tk) begin
            if (pc == 1) pf = 1;
            if (pc > 0) pc--;
            if (ac == 1) af = 1;
            if (ac > 0) ac--;
        end
        if (d && pkt_delay != 0) begin
            pc = int'(pkt_delay); pf = 0;
            if (abs_delay != 0 && !abs_run) ac = int'(abs_delay);
        end
        e_rxt = pf || af || (d && pkt_delay == 0);
        e_small = d && small_thresh != 0 && len <= int'(small_thresh);
        m_pc = pc; m_ac = ac;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        done_vld = 0; tick_en = 0; cancel = 0;
    endtask

    task automatic idle(input int n, input bit tk, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, tk, 0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1_reset");

        // R2 R3: packet timer with sparse ticks
        pkt_delay = 3; abs_delay = 0; small_thresh = 0;
        step(1, 100, 0, 0, "R2_load");
        idle(4, 0, "R3_no_tick_holds");
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 1, 0, "R3_count");
            idle(2, 0, "R3_gap");
        end
        // R2: restart discards the old count
        step(1, 100, 1, 0, "R2_start");
        step(0, 0, 1, 0, "R2_tick");
        step(1, 100, 0, 0, "R2_restart");
        idle(5, 1, "R2_after_restart");

        // R9: completion on the would-be expiry tick
        pkt_delay = 2;
        step(1, 100, 0, 0, "R9_start");
        step(0, 0, 1, 0, "R9_tick");
        step(1, 100, 1, 0, "R9_collide");
        idle(4, 1, "R9_after");

        // R4: absolute timer started once per burst
        pkt_delay = 4; abs_delay = 6;
        for (int i = 0; i < 4; i++) begin
            step(1, 200, 1, 0, "R4_burst");
            step(0, 0, 1, 0, "R4_burst_gap");
        end
        idle(8, 1, "R4_drain");
        // R4 R5: absolute delay set but packet delay zero
        pkt_delay = 0; abs_delay = 5;
        step(1, 200, 1, 0, "R5_immediate");
        idle(3, 1, "R4_no_abs_start");
        step(1, 200, 0, 0, "R5_immediate2");
        step(1, 200, 0, 0, "R5_back_to_back");
        idle(2, 0, "R5_after");

        // R6 R7: small-frame detection
        small_thresh = 64;
        step(1, 64, 0, 0, "R6_equal");
        step(1, 65, 0, 0, "R6_above");
        step(1, 1, 0, 0, "R6_below");
        idle(1, 0, "R6_after");
        small_thresh = 0;
        step(1, 0, 0, 0, "R7_zero_len");
        step(1, 10, 0, 0, "R7_disabled");
        idle(1, 0, "R7_after");

        // R8: cancel cases
        pkt_delay = 3; abs_delay = 8;
        step(1, 300, 0, 0, "R8_start");
        step(0, 0, 1, 0, "R8_tick");
        step(0, 0, 1, 1, "R8_cancel");
        idle(4, 1, "R8_silent");
        pkt_delay = 1; abs_delay = 0;
        step(1, 300, 0, 0, "R8_start2");
        step(0, 0, 1, 1, "R8_cancel_on_expiry");
        idle(2, 1, "R8_after");
        pkt_delay = 3; abs_delay = 8;
        step(1, 300, 1, 0, "R8_start3");
        step(1, 300, 1, 1, "R8_cancel_with_done");
        idle(10, 1, "R8_restart_run");

        // R10: simultaneous expiries merge into one pulse
        pkt_delay = 2; abs_delay = 2;
        step(1, 400, 0, 0, "R10_start");
        step(0, 0, 1, 0, "R10_tick");
        step(0, 0, 1, 0, "R10_both_expire");
        idle(3, 1, "R10_after");

        finish_run();
    end
endmodule